// File: doc/BRIEF.md
# Genome-Encoded Gate Array Evaluator

This block scores one candidate combinational circuit taken from a stored genome. The genome is a grid of gate cells. Each row is one candidate and each column is one logic level. Every cell names its gate kind and says where its two inputs come from. An input can come from a primary input variable or from any cell in an earlier column. Because of this, one grid holds as many overlapping circuits as it has rows. A circuit is picked by choosing which cell of the last column serves as the output.

Software, or a search engine beside the block, writes the genome one cell at a time through a register-write port. It then pulses `start` with a variable count, an output row and a target truth table. The block walks through every input combination, one per clock. It counts the rows where the chosen output disagrees with the target. It then traces backwards from the output to count the real (non-wire) gates that the output depends on. Both results appear with a one-cycle `done` pulse and stay put until the next evaluation finishes.

A reference to the cell's own column, a later column, a row outside the grid or an unused input variable reads as logic 0. When such a reference lies on the selected circuit, it raises a sticky `invalid_genome` flag.

Top module: `gate_genome_eval`

## Requirements
- R1: A cell word is 15 bits.
  - Fields from the top bit down: first-source row [14:12], first-source column [11:9], second-source row [8:6], second-source column [5:3], gate kind [2:0].
  - A write with `wr_en` high stores `wr_data` at row `wr_row` (1..5) and column `wr_col` (1..5) while the block is idle.
  - Writes with a row or column of 0 or above 5, and writes made while `busy` is high, change nothing.
- R2: The gate kind decodes as 0 wire (passes the first source), 1 AND, 2 OR, 3 XOR, 4 NAND, 5 NOR. Codes 6 and 7 output 0 and count as invalid when they lie on the selected circuit.
- R3: A source with column 0 and row k selects input variable k.
  - Variable 1 (A) is the most significant bit of the combination index, and variable n is bit 0.
  - Row 0, or a row above the active variable count, reads 0.
- R4: A cell source that names the cell's own column, a later column, row 0 or a row above 5 reads 0.
  - Such a source, or a bad input-variable source, on a cell reachable from the output sets `invalid_genome`.
  - The second source of a wire cell is never examined.
  - `invalid_genome` stays set until reset.
- R5: `out_row` (1..5) selects the last-column cell that drives the output. Any other value gives a constant-0 output, a gate count of 0 and a set `invalid_genome`.
- R6: `error_count` equals the number of combinations i in 0..2^n-1 for which the output differs from `target[i]`. Here n is `num_inputs`, and any value above 5 is treated as 5.
- R7: `gate_count` equals the number of non-wire cells reachable from the selected output through first sources, and through second sources of non-wire cells.
- R8: A `start` seen while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, 2^n+1 cycles after the start edge, with `busy` falling on the same edge.
- R9: `error_count` and `gate_count` change only on the edge that raises `done`. A `start` while busy is ignored.
- R10: Reset clears `done`, `busy`, both counts and `invalid_genome`, and leaves the stored genome intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Cell write strobe |
| wr_row | input | 3 | Row of the written cell, 1-based |
| wr_col | input | 3 | Column of the written cell, 1-based |
| wr_data | input | 15 | Cell word |
| num_inputs | input | 3 | Active variable count, clamped to 5 |
| out_row | input | 3 | Last-column row used as output |
| target | input | 32 | Expected output per combination index |
| start | input | 1 | Begin an evaluation |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| error_count | output | 6 | Mismatching truth-table rows |
| gate_count | output | 5 | Reachable non-wire cells |
| invalid_genome | output | 1 | Sticky bad-reference flag |

## Verification
A wrong per-cell value, for example a mis-decoded gate kind or a misrouted source, shows up only as a wrong `error_count` on the next `done`. It also needs a target that separates the two functions, so the bench mixes directed parity circuits with many random genomes, rows and targets, all compared against an independent model. A wrong reachability mark shows up at the same `done` as a wrong `gate_count` or a spurious `invalid_genome`. That flag is sticky, so the error then persists until reset. A wrong sequencer state shows up within the run as a `done` at the wrong cycle, or as a second `done` for one start. A leak in the write lock shows up one evaluation later, as changed counts for an unchanged request.

// File: rtl/gaev_pkg.sv
package gaev_pkg;
  parameter int FIELD_W = 3;
  parameter int KIND_W  = 3;

  typedef logic [FIELD_W-1:0] fld_t;
  typedef logic [KIND_W-1:0]  kind_t;

  typedef enum logic [KIND_W-1:0] {
    K_WIRE = 3'd0,
    K_AND  = 3'd1,
    K_OR   = 3'd2,
    K_XOR  = 3'd3,
    K_NAND = 3'd4,
    K_NOR  = 3'd5
  } kind_e;

  typedef struct packed {
    fld_t  a_row;
    fld_t  a_col;
    fld_t  b_row;
    fld_t  b_col;
    kind_t kind;
  } cell_t;

  localparam int CELL_W = $bits(cell_t);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seq_e;

  function automatic logic gate_fn(input kind_t k, input logic a, input logic b);
    logic y;
    case (k)
      K_WIRE:  y = a;
      K_AND:   y = a & b;
      K_OR:    y = a | b;
      K_XOR:   y = a ^ b;
      K_NAND:  y = ~(a & b);
      K_NOR:   y = ~(a | b);
      default: y = 1'b0;
    endcase
    return y;
  endfunction

  function automatic logic uses_b(input kind_t k);
    return k != K_WIRE;
  endfunction

  function automatic logic kind_ok(input kind_t k);
    return k <= K_NOR;
  endfunction
endpackage

// File: rtl/gaev_store.sv
module gaev_store
  import gaev_pkg::*;
#(
  parameter int ROWS = 5,
  parameter int COLS = 5,
  localparam int NODES = ROWS * COLS
)(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lock,
  input  logic  wr_en,
  input  fld_t  wr_row,
  input  fld_t  wr_col,
  input  cell_t wr_data,
  output cell_t cells [NODES]
);
  logic row_ok, col_ok, wr_take;

  always_comb begin
    row_ok  = (wr_row != '0) && (int'(wr_row) <= ROWS);
    col_ok  = (wr_col != '0) && (int'(wr_col) <= COLS);
    wr_take = wr_en && !lock && row_ok && col_ok;
  end

  for (genvar gc = 1; gc <= COLS; gc++) begin : g_col
    for (genvar gr = 1; gr <= ROWS; gr++) begin : g_row
      localparam int N = (gc - 1) * ROWS + (gr - 1);
      logic hit;
      cell_t mem_q;
      assign hit = wr_take && (int'(wr_row) == gr) && (int'(wr_col) == gc);
      // genome storage carries no reset: it is kept across reset
      always_ff @(posedge clk) begin
        if (hit) mem_q <= wr_data;
      end
      assign cells[N] = mem_q;
    end
  end

  // R1: the stored genome cannot move while an evaluation holds the lock
  p_locked_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && $past(lock)) |-> $stable(cells[0]) && $stable(cells[NODES-1]));
endmodule

// File: rtl/gaev_grid.sv
module gaev_grid
  import gaev_pkg::*;
#(
  parameter int ROWS   = 5,
  parameter int COLS   = 5,
  parameter int MAX_IN = 5,
  parameter int IN_W   = 3,
  localparam int NODES = ROWS * COLS
)(
  input  cell_t              cells [NODES],
  input  logic [MAX_IN-1:0]  combo,
  input  logic [IN_W-1:0]    nin,
  input  fld_t               sel_row,
  output logic               out_bit
);
  // prim[k] is variable k for the current combination; prim[0] is tied low
  logic [MAX_IN:0] prim;
  assign prim[0] = 1'b0;

  for (genvar gk = 1; gk <= MAX_IN; gk++) begin : g_var
    always_comb begin
      prim[gk] = 1'b0;
      if (IN_W'(gk) <= nin) prim[gk] = combo[nin - IN_W'(gk)];
    end
  end

  function automatic logic pick(input fld_t r, input fld_t c, input int here,
                                input logic [MAX_IN:0] pv,
                                input logic [NODES-1:0] pr);
    int n;
    if (c == '0) return (int'(r) <= MAX_IN) ? pv[r] : 1'b0;
    if (int'(c) >= here || r == '0 || int'(r) > ROWS) return 1'b0;
    n = (int'(c) - 1) * ROWS + int'(r) - 1;
    return pr[n];
  endfunction

  // seen[c] holds the values of every cell in columns 1..c
  logic [NODES-1:0] seen [COLS+1];
  assign seen[0] = '0;

  for (genvar gc = 1; gc <= COLS; gc++) begin : g_col
    logic [ROWS-1:0] colv;
    for (genvar gr = 1; gr <= ROWS; gr++) begin : g_row
      localparam int N = (gc - 1) * ROWS + (gr - 1);
      logic a_v, b_v;
      always_comb begin
        a_v = pick(cells[N].a_row, cells[N].a_col, gc, prim, seen[gc-1]);
        b_v = pick(cells[N].b_row, cells[N].b_col, gc, prim, seen[gc-1]);
        colv[gr-1] = gate_fn(cells[N].kind, a_v, b_v);
      end
    end
    assign seen[gc] = seen[gc-1] | (NODES'(colv) << ((gc - 1) * ROWS));
  end

  always_comb begin
    out_bit = 1'b0;
    if (sel_row != '0 && int'(sel_row) <= ROWS)
      out_bit = seen[COLS][(COLS - 1) * ROWS + int'(sel_row) - 1];
  end
endmodule

// File: rtl/gaev_trace.sv
module gaev_trace
  import gaev_pkg::*;
#(
  parameter int ROWS   = 5,
  parameter int COLS   = 5,
  parameter int IN_W   = 3,
  parameter int GC_W   = 5,
  localparam int NODES = ROWS * COLS
)(
  input  cell_t           cells [NODES],
  input  logic [IN_W-1:0] nin,
  input  fld_t            sel_row,
  output logic [GC_W-1:0] gate_total,
  output logic            bad
);
  function automatic logic [NODES-1:0] ref_bit(input fld_t r, input fld_t c, input int here);
    logic [NODES-1:0] v;
    v = '0;
    if (c != '0 && int'(c) < here && r != '0 && int'(r) <= ROWS)
      v[(int'(c) - 1) * ROWS + int'(r) - 1] = 1'b1;
    return v;
  endfunction

  function automatic logic ref_bad(input fld_t r, input fld_t c, input int here,
                                   input logic [IN_W-1:0] ni);
    if (c == '0) return (r == '0) || (int'(r) > int'(ni));
    return (int'(c) >= here) || (r == '0) || (int'(r) > ROWS);
  endfunction

  logic             sel_ok;
  logic [NODES-1:0] need  [1:COLS];
  logic [NODES-1:0] cref  [NODES];
  logic             cbad  [NODES];
  logic             cgate [NODES];

  assign sel_ok = (sel_row != '0) && (int'(sel_row) <= ROWS);
  assign need[COLS] = sel_ok ? (NODES'(1) << ((COLS - 1) * ROWS + int'(sel_row) - 1)) : '0;

  for (genvar gc = COLS; gc >= 1; gc--) begin : g_col
    for (genvar gr = 1; gr <= ROWS; gr++) begin : g_row
      localparam int N = (gc - 1) * ROWS + (gr - 1);
      logic mark;
      assign mark = need[gc][N];
      assign cref[N] = mark ? (ref_bit(cells[N].a_row, cells[N].a_col, gc) |
                               (uses_b(cells[N].kind) ?
                                ref_bit(cells[N].b_row, cells[N].b_col, gc) : '0)) : '0;
      assign cbad[N] = mark & (ref_bad(cells[N].a_row, cells[N].a_col, gc, nin) |
                               (uses_b(cells[N].kind) &
                                ref_bad(cells[N].b_row, cells[N].b_col, gc, nin)) |
                               !kind_ok(cells[N].kind));
      assign cgate[N] = mark & uses_b(cells[N].kind);
    end
    if (gc > 1) begin : g_down
      logic [NODES-1:0] acc;
      always_comb begin
        acc = need[gc];
        for (int r = 0; r < ROWS; r++) acc = acc | cref[(gc - 1) * ROWS + r];
      end
      assign need[gc-1] = acc;
    end
  end

  always_comb begin
    gate_total = '0;
    bad        = !sel_ok;
    for (int n = 0; n < NODES; n++) begin
      gate_total = gate_total + GC_W'(cgate[n]);
      bad        = bad | cbad[n];
    end
  end
endmodule

// File: rtl/gate_genome_eval.sv
module gate_genome_eval
  import gaev_pkg::*;
#(
  parameter int ROWS   = 5,
  parameter int COLS   = 5,
  parameter int MAX_IN = 5,
  localparam int TT_W  = 1 << MAX_IN,
  localparam int IN_W  = $clog2(MAX_IN + 1),
  localparam int NODES = ROWS * COLS,
  localparam int GC_W  = $clog2(NODES + 1),
  localparam int EC_W  = MAX_IN + 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_row,
  input  logic [FIELD_W-1:0] wr_col,
  input  logic [CELL_W-1:0]  wr_data,
  input  logic [IN_W-1:0]    num_inputs,
  input  logic [FIELD_W-1:0] out_row,
  input  logic [TT_W-1:0]    target,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [EC_W-1:0]    error_count,
  output logic [GC_W-1:0]    gate_count,
  output logic               invalid_genome
);
  // reset: asserted asynchronously, released through two flops
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  seq_e              st_q, st_d;
  logic [MAX_IN-1:0] idx_q, idx_d;
  logic [EC_W-1:0]   acc_q, acc_d;
  logic [IN_W-1:0]   nin_q, nin_clamp;
  fld_t              sel_q;
  logic [TT_W-1:0]   tgt_q;
  logic              done_q, done_d;
  logic [EC_W-1:0]   ecnt_q;
  logic [GC_W-1:0]   gcnt_q;
  logic              inv_q;
  logic              cfg_en, res_en;
  logic [MAX_IN-1:0] last_idx;
  logic              grid_out, miss;
  logic [GC_W-1:0]   gate_total;
  logic              trace_bad;
  cell_t             cells [NODES];

  gaev_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk     (clk),
    .rst_n   (rst_s),
    .lock    (st_q != ST_IDLE),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_col  (wr_col),
    .wr_data (cell_t'(wr_data)),
    .cells   (cells)
  );

  gaev_grid #(.ROWS(ROWS), .COLS(COLS), .MAX_IN(MAX_IN), .IN_W(IN_W)) u_grid (
    .cells   (cells),
    .combo   (idx_q),
    .nin     (nin_q),
    .sel_row (sel_q),
    .out_bit (grid_out)
  );

  gaev_trace #(.ROWS(ROWS), .COLS(COLS), .IN_W(IN_W), .GC_W(GC_W)) u_trace (
    .cells      (cells),
    .nin        (nin_q),
    .sel_row    (sel_q),
    .gate_total (gate_total),
    .bad        (trace_bad)
  );

  always_comb begin
    nin_clamp = (int'(num_inputs) > MAX_IN) ? IN_W'(MAX_IN) : num_inputs;
    last_idx  = MAX_IN'((1 << nin_q) - 1);
    miss      = grid_out ^ tgt_q[idx_q];
    cfg_en    = (st_q == ST_IDLE) && start;
    res_en    = (st_q == ST_FIN);
  end

  // next-state process
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_RUN;
          idx_d = '0;
          acc_d = '0;
        end
      end
      ST_RUN: begin
        acc_d = acc_q + EC_W'(miss);
        if (idx_q == last_idx) st_d = ST_FIN;
        else                   idx_d = idx_q + 1'b1;
      end
      ST_FIN: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
      nin_q  <= '0;
      sel_q  <= '0;
      tgt_q  <= '0;
      ecnt_q <= '0;
      gcnt_q <= '0;
      inv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      done_q <= done_d;
      if (cfg_en) begin
        nin_q <= nin_clamp;
        sel_q <= out_row;
        tgt_q <= target;
      end
      if (res_en) begin
        ecnt_q <= acc_q;
        gcnt_q <= gate_total;
        inv_q  <= inv_q | trace_bad;
      end
    end
  end

  assign busy           = (st_q != ST_IDLE);
  assign done           = done_q;
  assign error_count    = ecnt_q;
  assign gate_count     = gcnt_q;
  assign invalid_genome = inv_q;

  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (start && !busy) |=> busy);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> !busy);
  p_hold_counts_r9: assert property (@(posedge clk) disable iff (!rst_s)
    !done |-> ($stable(error_count) && $stable(gate_count)));
  p_sticky_flag_r4: assert property (@(posedge clk) disable iff (!rst_s)
    invalid_genome |=> invalid_genome);
  p_err_bound_r6: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (int'(error_count) <= (1 << nin_q)));
endmodule

// File: tb/sim_gate_genome_eval.sv
module sim_gate_genome_eval;
  localparam int ROWS = 5, COLS = 5;

  logic        clk, rst_n, wr_en, start;
  logic [2:0]  wr_row, wr_col, num_inputs, out_row;
  logic [14:0] wr_data;
  logic [31:0] target;
  logic        busy, done, invalid_genome;
  logic [5:0]  error_count;
  logic [4:0]  gate_count;

  gate_genome_eval u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .num_inputs(num_inputs), .out_row(out_row),
    .target(target), .start(start), .busy(busy), .done(done),
    .error_count(error_count), .gate_count(gate_count),
    .invalid_genome(invalid_genome)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_fail = 0, done_cnt = 0, start_cyc = 0;

  typedef struct {
    int    err;
    int    gates;
    bit    inv;
    int    lat;
    string tag;
  } exp_t;
  exp_t sb[$];

  // bench model of the genome
  logic [14:0] gm [1:ROWS][1:COLS];
  bit          mv [1:ROWS][1:COLS];
  bit          mm [1:ROWS][1:COLS];
  bit          inv_model = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(int ar, int ac, int br, int bc, int k);
    return {3'(ar), 3'(ac), 3'(br), 3'(bc), 3'(k)};
  endfunction

  function automatic bit m_gate(int k, bit a, bit b);
    case (k)
      0: return a;
      1: return a & b;
      2: return a | b;
      3: return a ^ b;
      4: return !(a & b);
      5: return !(a | b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_src(int sr, int sc, int here, int i, int ne);
    if (sc == 0) return (sr >= 1 && sr <= ne) ? bit'((i >> (ne - sr)) & 1) : 1'b0;
    if (sc >= here || sr < 1 || sr > ROWS) return 1'b0;
    return mv[sr][sc];
  endfunction

  function automatic bit m_ref(int sr, int sc, int here, int ne);
    if (sc == 0) return (sr == 0 || sr > ne);
    if (sc >= here || sr == 0 || sr > ROWS) return 1'b1;
    mm[sr][sc] = 1'b1;
    return 1'b0;
  endfunction

  task automatic model_run(input int nin, input int orow, input logic [31:0] tgt,
                           output int err, output int gates, output bit bad);
    int ne;
    bit o;
    ne = (nin > 5) ? 5 : nin;
    err = 0;
    for (int i = 0; i < (1 << ne); i++) begin
      for (int c = 1; c <= COLS; c++)
        for (int r = 1; r <= ROWS; r++) begin
          logic [14:0] w;
          w = gm[r][c];
          mv[r][c] = m_gate(int'(w[2:0]),
                            m_src(int'(w[14:12]), int'(w[11:9]), c, i, ne),
                            m_src(int'(w[8:6]), int'(w[5:3]), c, i, ne));
        end
      o = (orow >= 1 && orow <= ROWS) ? mv[orow][COLS] : 1'b0;
      if (o != tgt[i]) err++;
    end
    for (int c = 1; c <= COLS; c++)
      for (int r = 1; r <= ROWS; r++) mm[r][c] = 1'b0;
    gates = 0;
    bad = !(orow >= 1 && orow <= ROWS);
    if (!bad) mm[orow][COLS] = 1'b1;
    for (int c = COLS; c >= 1; c--)
      for (int r = 1; r <= ROWS; r++)
        if (mm[r][c]) begin
          logic [14:0] w;
          int k;
          w = gm[r][c];
          k = int'(w[2:0]);
          if (k != 0) gates++;
          if (k > 5) bad = 1'b1;
          if (m_ref(int'(w[14:12]), int'(w[11:9]), c, ne)) bad = 1'b1;
          if (k != 0 && m_ref(int'(w[8:6]), int'(w[5:3]), c, ne)) bad = 1'b1;
        end
  endtask

  // monitor: pop expected results as the design reports them
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(int'(error_count) == e.err, "R6", {e.tag, " error_count"}, error_count, e.err);
        chk(int'(gate_count) == e.gates, "R7", {e.tag, " gate_count"}, gate_count, e.gates);
        chk(invalid_genome == e.inv, "R4", {e.tag, " invalid_genome"}, invalid_genome, e.inv);
        chk(cyc - start_cyc == e.lat, "R8", {e.tag, " done latency"}, cyc - start_cyc, e.lat);
      end
      done_cnt++;
    end
  end

  task automatic write_cell(input int r, input int c, input logic [14:0] w, input bit model);
    @(negedge clk);
    wr_en = 1'b1; wr_row = 3'(r); wr_col = 3'(c); wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    if (model) gm[r][c] = w;
  endtask

  // disturb: 1 = write a cell and re-pulse start while busy
  task automatic run_eval(input int nin, input int orow, input logic [31:0] tgt,
                          input string tag, input int disturb);
    exp_t e;
    int err, gates, prev, ne;
    bit bad;
    model_run(nin, orow, tgt, err, gates, bad);
    inv_model = inv_model | bad;
    ne = (nin > 5) ? 5 : nin;
    e.err = err; e.gates = gates; e.inv = inv_model; e.lat = (1 << ne) + 1; e.tag = tag;
    sb.push_back(e);
    prev = done_cnt;
    @(negedge clk);
    num_inputs = 3'(nin); out_row = 3'(orow); target = tgt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    start_cyc = cyc;
    chk(busy == 1'b1, "R8", {tag, " busy after start"}, busy, 1);
    if (disturb == 1) begin
      wr_en = 1'b1; wr_row = 3'd1; wr_col = 3'd5; wr_data = mk(2, 1, 3, 2, 4);
      start = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; start = 1'b0;
    end
    while (done_cnt == prev) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R8", {tag, " done one cycle"}, done, 0);
    chk(busy == 1'b0, "R8", {tag, " idle after done"}, busy, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    inv_model = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int err, gates;
    bit bad;
    wr_en = 0; start = 0; wr_row = 0; wr_col = 0; wr_data = 0;
    num_inputs = 0; out_row = 0; target = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(done == 0, "R10", "done at reset", done, 0);
    chk(busy == 0, "R10", "busy at reset", busy, 0);
    chk(error_count == 0, "R10", "error_count at reset", error_count, 0);
    chk(gate_count == 0, "R10", "gate_count at reset", gate_count, 0);
    chk(invalid_genome == 0, "R10", "flag at reset", invalid_genome, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1/R2: filler wires from variable A, then a two-gate parity on row 1
    for (int c = 1; c <= COLS; c++)
      for (int r = 1; r <= ROWS; r++) write_cell(r, c, mk(1, 0, 1, 0, 0), 1);
    write_cell(1, 1, mk(1, 0, 2, 0, 3), 1);
    write_cell(1, 2, mk(1, 1, 3, 0, 3), 1);
    for (int c = 3; c <= COLS; c++) write_cell(1, c, mk(1, c - 1, 0, 0, 0), 1);
    model_run(3, 1, 32'h96, err, gates, bad);
    chk(err == 0 && gates == 2 && !bad, "R2", "model parity sanity", err * 100 + gates, 2);
    run_eval(3, 1, 32'h0000_0096, "R2 parity exact", 0);
    run_eval(3, 1, 32'h0000_0097, "R6 parity one miss", 0);

    // R3: row 2 is NOR(NAND(A,B), C) with variable ordering A as MSB
    write_cell(2, 1, mk(1, 0, 2, 0, 4), 1);
    write_cell(2, 2, mk(2, 1, 3, 0, 5), 1);
    for (int c = 3; c <= COLS; c++) write_cell(2, c, mk(2, c - 1, 0, 0, 0), 1);
    run_eval(3, 2, 32'h0000_0040, "R3 nand-nor row2", 0);
    run_eval(2, 2, 32'h0000_0000, "R3 two variables", 0);

    // R6: variable count above five is clamped
    run_eval(7, 1, 32'h6996_9669, "R6 clamp count", 0);

    // R5/R4: row 0 output, then sticky flag on a clean run
    run_eval(3, 0, 32'h0000_00F0, "R5 bad out_row", 0);
    run_eval(3, 1, 32'h0000_0096, "R4 sticky flag", 0);

    // R10: reset clears flag, genome retained
    do_reset();
    chk(invalid_genome == 0, "R10", "flag after reset", invalid_genome, 0);
    chk(error_count == 0, "R10", "error_count after reset", error_count, 0);
    run_eval(3, 1, 32'h0000_0096, "R10 genome kept", 0);

    // R4: forward reference and unused-variable reference
    write_cell(3, 4, mk(3, 5, 1, 0, 1), 1);
    write_cell(3, 5, mk(3, 4, 0, 0, 0), 1);
    run_eval(3, 3, 32'h0000_0000, "R4 forward ref", 0);
    do_reset();
    write_cell(4, 5, mk(5, 0, 1, 0, 2), 1);
    run_eval(3, 4, 32'h0000_00F0, "R4 unused var", 0);
    do_reset();

    // R1/R9: write and start while busy, then rerun unchanged
    run_eval(3, 1, 32'h0000_0096, "R9 busy disturb", 1);
    run_eval(3, 1, 32'h0000_0096, "R1 locked write", 0);
    // R1: out-of-range addresses are ignored
    write_cell(0, 5, mk(7, 7, 7, 7, 7), 0);
    write_cell(1, 6, mk(7, 7, 7, 7, 7), 0);
    run_eval(3, 1, 32'h0000_0096, "R1 bad address", 0);

    // R2/R3/R7: random genomes
    for (int g = 0; g < 8; g++) begin
      for (int c = 1; c <= COLS; c++)
        for (int r = 1; r <= ROWS; r++) begin
          logic [14:0] w;
          if ($urandom_range(0, 11) == 0) w = 15'($urandom);
          else begin
            int ac, bc, ar, br;
            ac = $urandom_range(0, c - 1);
            bc = $urandom_range(0, c - 1);
            ar = (ac == 0) ? $urandom_range(1, 5) : $urandom_range(1, ROWS);
            br = (bc == 0) ? $urandom_range(1, 5) : $urandom_range(1, ROWS);
            w = mk(ar, ac, br, bc, $urandom_range(0, 5));
          end
          write_cell(r, c, w, 1);
        end
      for (int r = 1; r <= ROWS; r++)
        run_eval($urandom_range(1, 5), r, $urandom, "R7 random genome", 0);
      do_reset();
    end

    chk(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
    summary();
    $finish;
  end
endmodule